// File: doc/BRIEF.md
# Software Trace Event Generator

This block lets software emit lightweight trace events without stopping the core. It watches the core's register-file write port and keeps a copy of the last 64-bit value written to the first argument register, a0 (x10). When software writes an identifier to a dedicated CSR, the block builds one trace event from three parts: the low 16 bits of that CSR data as the identifier, the kept a0 value as the payload, and a 32-bit cycle timestamp taken in the cycle of the CSR write. The event then waits in a small queue until the debug network accepts it over a valid/ready handshake.

When the queue is full, new events are thrown away and a saturating counter records how many were lost. As soon as a slot frees up, the block inserts an overflow record that carries this count, ahead of any later event, and then clears the counter. A consumer can therefore tell exactly where events went missing and how many.

Top module: `swTraceGen`

## Requirements
- R1: After reset, outValid is low and stays low until an event is created.
- R2: A register write with regWrAddr equal to 10 replaces the kept a0 value, and the last such write wins. Writes to any other register index leave the kept value unchanged.
- R3: A CSR write with csrWrAddr equal to 0x8F0 creates an event with outKind 0, outId equal to csrWrData[15:0] (upper bits ignored) and outValue equal to the kept a0 value. CSR writes to any other address create nothing.
- R4: When a0 and the trigger CSR are written in the same cycle, the event carries the a0 value held before that cycle, and the new value is kept for later events.
- R5: Every cycle with a trigger CSR write creates its own event, including back-to-back writes that carry the same identifier.
- R6: outStamp is a 32-bit count of clock cycles that advances by one per cycle. The stamps of two events differ by exactly the number of cycles between their trigger writes.
- R7: Events and records leave in the order they were created. While outValid is high and outReady is low, every output field holds steady.
- R8: The queue holds DEPTH entries (4 by default). A trigger write that finds it full is dropped and raises the drop count.
- R9: Once there are pending drops and a free slot, an overflow record (outKind 1, outId 0, outValue equal to the drop count) is queued before any later event, and the count returns to zero.
- R10: The drop count saturates at its all-ones value (2^DROP_W - 1) and does not wrap.
- R11: If a trigger write arrives while drops are pending and only one slot is free, that slot takes the overflow record, the new event is dropped, and the drop count restarts at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register-file write strobe from the core |
| regWrAddr | input | 5 | Register index being written |
| regWrData | input | 64 | Register write data |
| csrWrEn | input | 1 | Decoded CSR write strobe |
| csrWrAddr | input | 12 | CSR address being written |
| csrWrData | input | 64 | CSR write data; low 16 bits form the event id |
| outValid | output | 1 | Queue head holds an event or record |
| outReady | input | 1 | Debug network accepts the head |
| outKind | output | 1 | 0 = trace event, 1 = overflow record |
| outId | output | 16 | Event identifier (0 for records) |
| outValue | output | 64 | a0 payload, or the drop count for records |
| outStamp | output | 32 | Cycle timestamp of creation |

## Verification
The bench builds the block with the default queue depth of 4 and narrows DROP_W to 4. With that width, the drop count saturates at 15 after a short burst of lost events, so saturation is checked directly instead of needing tens of thousands of drops. The shallow queue means a handful of back-to-back trigger writes is enough to fill it, trigger drops, and create the case where only a single slot is free for both a record and an event.

// File: rtl/swTracePkg.sv
package swTracePkg;

  typedef enum logic {
    KIND_EVENT    = 1'b0,
    KIND_OVERFLOW = 1'b1
  } pktKindT;

  // strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic pushRec;   // queue an overflow record
    logic pushEvt;   // queue the trace event (after the record if both)
    logic dropInc;   // one event lost this cycle
    logic dropClr;   // drop count consumed by a record
    logic pop;       // head accepted by the network
  } traceStrobesT;

endpackage

// File: rtl/swTraceCtrl.sv
module swTraceCtrl
  import swTracePkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int CNT_W    = 3,
  parameter logic [11:0] CSR_ADDR = 12'h8F0
) (
  input  logic             csrWrEn,
  input  logic [11:0]      csrWrAddr,
  input  logic [CNT_W-1:0] fillCount,
  input  logic             dropPend,
  input  logic             outReady,
  output logic             evtHit,
  output traceStrobesT     strb
);

  logic [CNT_W-1:0] freeSlots;
  logic             hasOne;
  logic             hasTwo;

  assign evtHit    = csrWrEn && (csrWrAddr == CSR_ADDR);
  assign freeSlots = CNT_W'(DEPTH) - fillCount;
  assign hasOne    = freeSlots != '0;
  assign hasTwo    = freeSlots >= CNT_W'(2);

  always_comb begin
    strb         = '0;
    strb.pop     = (fillCount != '0) && outReady;
    if (evtHit) begin
      if (dropPend) begin
        if (hasTwo) begin
          strb.pushRec = 1'b1;
          strb.pushEvt = 1'b1;
          strb.dropClr = 1'b1;
        end else if (hasOne) begin
          strb.pushRec = 1'b1;
          strb.dropClr = 1'b1;
          strb.dropInc = 1'b1;
        end else begin
          strb.dropInc = 1'b1;
        end
      end else if (hasOne) begin
        strb.pushEvt = 1'b1;
      end else begin
        strb.dropInc = 1'b1;
      end
    end else if (dropPend && hasOne) begin
      strb.pushRec = 1'b1;
      strb.dropClr = 1'b1;
    end
  end

endmodule

// File: rtl/swTraceDatapath.sv
module swTraceDatapath
  import swTracePkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int VAL_W  = 64,
  parameter int ID_W   = 16,
  parameter int TS_W   = 32,
  parameter int DROP_W = 16,
  parameter int A0_IDX = 10,
  parameter int CNT_W  = 3,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [4:0]        regWrAddr,
  input  logic [VAL_W-1:0]  regWrData,
  input  logic [ID_W-1:0]   evtId,
  input  traceStrobesT      strb,
  output logic [CNT_W-1:0]  fillCount,
  output logic [DROP_W-1:0] dropCount,
  output logic              dropPend,
  output logic              outValid,
  output pktKindT           outKind,
  output logic [ID_W-1:0]   outId,
  output logic [VAL_W-1:0]  outValue,
  output logic [TS_W-1:0]   outStamp
);

  logic [VAL_W-1:0] a0Q;
  logic [TS_W-1:0]  stampNow;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] evtPtr;

  pktKindT          kindMem  [DEPTH];
  logic [ID_W-1:0]  idMem    [DEPTH];
  logic [VAL_W-1:0] valMem   [DEPTH];
  logic [TS_W-1:0]  stampMem [DEPTH];

  // shadow of a0
  always_ff @(posedge clk) begin
    if (!rstN)                                          a0Q <= '0;
    else if (regWrEn && regWrAddr == 5'(A0_IDX))        a0Q <= regWrData;
  end

  // free-running cycle stamp
  always_ff @(posedge clk) begin
    if (!rstN) stampNow <= '0;
    else       stampNow <= stampNow + TS_W'(1);
  end

  // saturating drop counter
  always_ff @(posedge clk) begin
    if (!rstN)
      dropCount <= '0;
    else if (strb.dropClr)
      dropCount <= strb.dropInc ? DROP_W'(1) : '0;
    else if (strb.dropInc && dropCount != '1)
      dropCount <= dropCount + DROP_W'(1);
  end

  assign dropPend = dropCount != '0;
  assign evtPtr   = wrPtr + PTR_W'(strb.pushRec);

  // queue storage
  always_ff @(posedge clk) begin
    if (strb.pushRec) begin
      kindMem[wrPtr]  <= KIND_OVERFLOW;
      idMem[wrPtr]    <= '0;
      valMem[wrPtr]   <= VAL_W'(dropCount);
      stampMem[wrPtr] <= stampNow;
    end
    if (strb.pushEvt) begin
      kindMem[evtPtr]  <= KIND_EVENT;
      idMem[evtPtr]    <= evtId;
      valMem[evtPtr]   <= a0Q;
      stampMem[evtPtr] <= stampNow;
    end
  end

  // queue pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      wrPtr     <= wrPtr + PTR_W'(strb.pushRec) + PTR_W'(strb.pushEvt);
      rdPtr     <= rdPtr + PTR_W'(strb.pop);
      fillCount <= fillCount + CNT_W'(strb.pushRec) + CNT_W'(strb.pushEvt)
                   - CNT_W'(strb.pop);
    end
  end

  assign outValid = fillCount != '0;
  assign outKind  = kindMem[rdPtr];
  assign outId    = idMem[rdPtr];
  assign outValue = valMem[rdPtr];
  assign outStamp = stampMem[rdPtr];

endmodule

// File: rtl/swTraceGen.sv
module swTraceGen
  import swTracePkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DROP_W = 16,
  parameter int A0_IDX = 10,
  parameter logic [11:0] CSR_ADDR = 12'h8F0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [4:0]  regWrAddr,
  input  logic [63:0] regWrData,
  input  logic        csrWrEn,
  input  logic [11:0] csrWrAddr,
  input  logic [63:0] csrWrData,
  output logic        outValid,
  input  logic        outReady,
  output logic        outKind,
  output logic [15:0] outId,
  output logic [63:0] outValue,
  output logic [31:0] outStamp
);

  localparam int VAL_W = 64;
  localparam int ID_W  = 16;
  localparam int TS_W  = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  traceStrobesT      strb;
  logic              evtHit;
  logic              dropPend;
  logic [CNT_W-1:0]  fillCount;
  logic [DROP_W-1:0] dropCount;
  pktKindT           headKind;

  swTraceCtrl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .CSR_ADDR(CSR_ADDR)
  ) u_ctrl (
    .csrWrEn(csrWrEn), .csrWrAddr(csrWrAddr), .fillCount(fillCount),
    .dropPend(dropPend), .outReady(outReady), .evtHit(evtHit), .strb(strb)
  );

  swTraceDatapath #(
    .DEPTH(DEPTH), .VAL_W(VAL_W), .ID_W(ID_W), .TS_W(TS_W),
    .DROP_W(DROP_W), .A0_IDX(A0_IDX), .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .evtId(csrWrData[ID_W-1:0]), .strb(strb),
    .fillCount(fillCount), .dropCount(dropCount), .dropPend(dropPend),
    .outValid(outValid), .outKind(headKind), .outId(outId),
    .outValue(outValue), .outStamp(outStamp)
  );

  assign outKind = headKind;

endmodule

// File: rtl/swTraceChecker.sv
module swTraceChecker #(
  parameter int DEPTH  = 4,
  parameter int DROP_W = 16,
  parameter int CNT_W  = 3,
  parameter logic [11:0] CSR_ADDR = 12'h8F0
) (
  input logic              clk,
  input logic              rstN,
  input logic              csrWrEn,
  input logic [11:0]       csrWrAddr,
  input logic              outValid,
  input logic              outReady,
  input logic              outKind,
  input logic [15:0]       outId,
  input logic [63:0]       outValue,
  input logic [31:0]       outStamp,
  input logic [CNT_W-1:0]  fillCount,
  input logic [DROP_W-1:0] dropCount
);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outKind) && $stable(outId)
      && $stable(outValue) && $stable(outStamp)); // R7

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH)); // R8

  AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    csrWrEn && csrWrAddr == CSR_ADDR && fillCount == CNT_W'(DEPTH)
      |=> dropCount != '0); // R8

  AST_DROP_NO_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    dropCount != '0 |=> dropCount >= $past(dropCount) || dropCount <= DROP_W'(1)); // R9

  AST_DROP_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    dropCount == '1 |=> dropCount == '1 || dropCount <= DROP_W'(1)); // R10

endmodule

bind swTraceGen swTraceChecker #(
  .DEPTH(DEPTH), .DROP_W(DROP_W), .CNT_W($clog2(DEPTH + 1)), .CSR_ADDR(CSR_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrAddr(csrWrAddr),
  .outValid(outValid), .outReady(outReady), .outKind(outKind), .outId(outId),
  .outValue(outValue), .outStamp(outStamp), .fillCount(fillCount),
  .dropCount(dropCount)
);

// File: tb/tb_swTraceGen.sv
module tb_swTraceGen;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] TRIG = 12'h8F0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regWrAddr = '0;
  logic [63:0] regWrData = '0;
  logic        csrWrEn = 1'b0;
  logic [11:0] csrWrAddr = '0;
  logic [63:0] csrWrData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        outKind;
  logic [15:0] outId;
  logic [63:0] outValue;
  logic [31:0] outStamp;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swTraceGen #(.DEPTH(4), .DROP_W(4)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .csrWrEn(csrWrEn), .csrWrAddr(csrWrAddr),
    .csrWrData(csrWrData), .outValid(outValid), .outReady(outReady),
    .outKind(outKind), .outId(outId), .outValue(outValue), .outStamp(outStamp)
  );

  typedef struct packed {
    logic [4:0]  regAddr;
    logic [63:0] regData;
    logic [11:0] csrAddr;
    logic [63:0] csrData;
    logic        emit;
    logic [15:0] expId;
    logic [63:0] expVal;
  } vecT;

  localparam vecT VECS [5] = '{
    '{5'd10, 64'h1111_2222_3333_4444, 12'h8F0, 64'h1001, 1'b1, 16'h1001, 64'h1111_2222_3333_4444},
    '{5'd11, 64'h2222_0000_0000_0000, 12'h8F0, 64'h1002, 1'b1, 16'h1002, 64'h1111_2222_3333_4444},
    '{5'd10, 64'he20c_000a_c20f_c588, 12'h8F0, 64'hABCD_1002, 1'b1, 16'h1002, 64'he20c_000a_c20f_c588},
    '{5'd10, 64'h5, 12'h8F1, 64'h1003, 1'b0, 16'h0, 64'h0},
    '{5'd10, 64'hffff_0800_000c_0000, 12'h8F0, 64'h1003, 1'b1, 16'h1003, 64'hffff_0800_000c_0000}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [63:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic writeCsr(input logic [11:0] a, input logic [63:0] d);
    csrWrEn = 1'b1; csrWrAddr = a; csrWrData = d;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic burst(input logic [15:0] firstId, input int n);
    csrWrEn = 1'b1; csrWrAddr = TRIG;
    for (int i = 0; i < n; i++) begin
      csrWrData = 64'(firstId) + 64'(i);
      @(negedge clk);
    end
    csrWrEn = 1'b0;
  endtask

  task automatic expectOut(input logic kind, input logic [15:0] id,
                           input logic [63:0] val, input string tag,
                           output logic [31:0] stamp);
    check(outValid == 1'b1, {tag, " valid"}, 64'(outValid), 64'd1);
    check(outKind == kind, {tag, " kind"}, 64'(outKind), 64'(kind));
    check(outId == id, {tag, " id"}, 64'(outId), 64'(id));
    check(outValue == val, {tag, " value"}, outValue, val);
    stamp = outStamp;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic expectEmpty(input string tag);
    check(outValid == 1'b0, {tag, " empty"}, 64'(outValid), 64'd0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] s0, s1, s2, sx;
    repeat (3) @(negedge clk);
    expectEmpty("R1 in reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expectEmpty("R1 after reset");

    // table of a0/CSR pairs: R2, R3
    for (int v = 0; v < 5; v++) begin
      writeReg(VECS[v].regAddr, VECS[v].regData);
      writeCsr(VECS[v].csrAddr, VECS[v].csrData);
      if (VECS[v].emit)
        expectOut(1'b0, VECS[v].expId, VECS[v].expVal, $sformatf("R2 R3 vec%0d", v), sx);
      else
        expectEmpty($sformatf("R3 vec%0d other CSR", v));
    end

    // R4: same-cycle a0 and trigger write
    writeReg(5'd10, 64'hAAAA);
    regWrEn = 1'b1; regWrAddr = 5'd10; regWrData = 64'hBBBB;
    csrWrEn = 1'b1; csrWrAddr = TRIG; csrWrData = 64'h4004;
    @(negedge clk);
    regWrEn = 1'b0; csrWrEn = 1'b0;
    expectOut(1'b0, 16'h4004, 64'hAAAA, "R4 old a0", sx);
    writeCsr(TRIG, 64'h4005);
    expectOut(1'b0, 16'h4005, 64'hBBBB, "R4 new a0 kept", sx);

    // R5 and R6: repeated id, stamp spacing
    burst(16'h0007, 1);
    burst(16'h0007, 1);
    repeat (3) @(negedge clk);
    writeCsr(TRIG, 64'h0007);
    expectOut(1'b0, 16'h0007, 64'hBBBB, "R5 first", s0);
    expectOut(1'b0, 16'h0007, 64'hBBBB, "R5 second", s1);
    expectOut(1'b0, 16'h0007, 64'hBBBB, "R5 third", s2);
    check(s1 - s0 == 32'd1, "R6 stamp gap 1", 64'(s1 - s0), 64'd1);
    check(s2 - s1 == 32'd4, "R6 stamp gap 4", 64'(s2 - s1), 64'd4);
    expectEmpty("R5 only three");

    // R7 R8 R9: fill, drop three, record before next event
    writeReg(5'd10, 64'hC0DE);
    burst(16'h0001, 7);
    repeat (2) @(negedge clk);
    check(outId == 16'h0001, "R7 stalled head", 64'(outId), 64'h1);
    expectOut(1'b0, 16'h0001, 64'hC0DE, "R7 order 1", sx);
    expectOut(1'b0, 16'h0002, 64'hC0DE, "R7 order 2", sx);
    expectOut(1'b0, 16'h0003, 64'hC0DE, "R7 order 3", sx);
    expectOut(1'b0, 16'h0004, 64'hC0DE, "R8 last stored", sx);
    expectOut(1'b1, 16'h0000, 64'd3, "R9 record count 3", sx);
    expectEmpty("R8 drops gone");
    writeCsr(TRIG, 64'h0009);
    expectOut(1'b0, 16'h0009, 64'hC0DE, "R9 count cleared, event follows", sx);
    expectEmpty("R9 no second record");

    // R11: one free slot, drops pending, trigger arrives
    burst(16'h0021, 6);
    expectOut(1'b0, 16'h0021, 64'hC0DE, "R11 head", sx);
    writeCsr(TRIG, 64'h0027);
    expectOut(1'b0, 16'h0022, 64'hC0DE, "R11 e2", sx);
    expectOut(1'b0, 16'h0023, 64'hC0DE, "R11 e3", sx);
    expectOut(1'b0, 16'h0024, 64'hC0DE, "R11 e4", sx);
    expectOut(1'b1, 16'h0000, 64'd2, "R11 record 2", sx);
    @(negedge clk);
    expectOut(1'b1, 16'h0000, 64'd1, "R11 record restart 1", sx);
    expectEmpty("R11 drained");

    // R10: saturation at 15 with DROP_W=4
    burst(16'h0031, 24);
    for (int k = 0; k < 4; k++)
      expectOut(1'b0, 16'h0031 + 16'(k), 64'hC0DE, "R10 stored", sx);
    expectOut(1'b1, 16'h0000, 64'd15, "R10 saturated record", sx);
    expectEmpty("R10 drained");

    finishRun();
  end

endmodule